// File: doc/BRIEF.md
# Analog Pin Test Access Control

This block is the digital control for a single analog function pin in a chip that supports boundary scan for mixed-signal circuits. It holds a four-bit segment of the boundary-scan register, with a capture/shift stage and a separate update stage. The TAP controller supplies the capture, shift and update strobes. The instruction decoder supplies the active instruction code.

The update word and the active instruction together set six switch enables around the pin:
- connection of the pin to its core circuit
- driving of the pin from analog test bus line 1
- observation of the pin onto analog test bus line 2
- high reference drive
- low reference drive
- quality ground reference drive

During capture, the segment records a one-bit comparator result that compares the pin voltage against a threshold. Interconnect tests can therefore run entirely on digital data. The analog switches and the comparator sit outside this block.

Top module: `abm_pin_ctrl`

## Requirements
- R1: When `rstN` is low, the update word is cleared to all zeros, and the block also holds the shift stage at zero. With a BYPASS code applied after reset, only `coreEn` is high.
- R2: On a clock edge with `captureEn` high, the segment loads as follows. Bit 0 (sense bit) takes `cmpIn`. Bits 1 (mode bit), 2 (drive bit) and 3 (observe bit) take the current update-stage values of those bits.
- R3: On a clock edge with `shiftEn` high and `captureEn` low, the segment moves one place towards bit 0. `scanIn` enters bit 3, and `scanOut` always shows bit 0. A word shifted in LSB first lands with bit i in segment bit i, and the previous contents leave LSB first.
- R4: The update word takes the segment value only on a clock edge with `updateEn` high. Shift or capture activity without an update leaves every switch enable unchanged.
- R5: Under SAMPLE (code 1), BYPASS (code 7) and every unassigned code (3 to 6), the outputs are as follows. `coreEn` is high and all other enables are low.
- R6: Under PROBE (code 2), `coreEn` is high. `busDriveEn` follows the drive bit and `busObsEn` follows the observe bit. All three reference enables are low.
- R7: Under EXTEST (code 0) with the mode bit set, `coreEn` and `busDriveEn` are low. The sense bit selects `refHighEn` (1) or `refLowEn` (0), and `busObsEn` follows the observe bit.
- R8: Under EXTEST with the mode bit clear, `coreEn` is low. If the drive and observe bits are both clear, only `refGndEn` is high. Otherwise `busDriveEn` and `busObsEn` follow those bits and the references stay off.
- R9: At most one of `refHighEn`, `refLowEn`, `refGndEn` and `busDriveEn` is high in any cycle, for every update word and instruction.
- R10: When `captureEn` and `shiftEn` are both high on an edge, the capture wins, as R2 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low test reset |
| captureEn | input | 1 | Capture strobe from the TAP controller |
| shiftEn | input | 1 | Shift strobe from the TAP controller |
| updateEn | input | 1 | Update strobe from the TAP controller |
| instr | input | INSTR_W | Active instruction code |
| scanIn | input | 1 | Serial data from the previous chain segment |
| cmpIn | input | 1 | Comparator result, pin voltage above threshold |
| scanOut | output | 1 | Serial data to the next chain segment |
| coreEn | output | 1 | Close the pin-to-core switch |
| busDriveEn | output | 1 | Close the switch from bus line 1 to the pin |
| busObsEn | output | 1 | Close the switch from the pin to bus line 2 |
| refHighEn | output | 1 | Drive the high reference onto the pin |
| refLowEn | output | 1 | Drive the low reference onto the pin |
| refGndEn | output | 1 | Drive the quality ground reference onto the pin |

## Verification
The bench builds the block with its defaults: a three-bit instruction code with EXTEST at 0, SAMPLE at 1, PROBE at 2 and BYPASS at 7. Because this leaves codes 3 to 6 unassigned, the default mapping path of R5 is reachable, alongside all four named modes. The three-bit width also lets an exhaustive sweep cover every update word under every code in 128 combinations. That sweep is how the single-source rule is exercised completely.

// File: rtl/abm_pkg.sv
`timescale 1ns/1ps
package abm_pkg;

  localparam int SEG_W = 4;

  // Segment bit positions; bit 0 sits nearest scanOut.
  localparam int B_SENSE = 0;
  localparam int B_MODE  = 1;
  localparam int B_DRIVE = 2;
  localparam int B_OBS   = 3;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } strobe_t;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'd0,
    MODE_PROBE  = 2'd1,
    MODE_EXTEST = 2'd2
  } mode_t;

  typedef struct packed {
    logic core;
    logic drive;
    logic obs;
    logic hi;
    logic lo;
    logic gnd;
  } sw_t;

endpackage

// File: rtl/abm_ctrl.sv
`timescale 1ns/1ps
module abm_ctrl
  import abm_pkg::*;
#(
  parameter int              INSTR_W     = 3,
  parameter logic [INSTR_W-1:0] CODE_EXTEST = 3'd0,
  parameter logic [INSTR_W-1:0] CODE_PROBE  = 3'd2
) (
  input  logic               captureEn,
  input  logic               shiftEn,
  input  logic               updateEn,
  input  logic [INSTR_W-1:0] instr,
  output strobe_t            strobe,
  output mode_t              mode
);

  // Capture has priority over shift; update is independent of both.
  always_comb begin
    strobe.capture = captureEn;
    strobe.shift   = shiftEn & ~captureEn;
    strobe.update  = updateEn;
  end

  // Any code other than the two test modes is treated as functional.
  always_comb begin
    if (instr == CODE_EXTEST)     mode = MODE_EXTEST;
    else if (instr == CODE_PROBE) mode = MODE_PROBE;
    else                          mode = MODE_FUNC;
  end

endmodule

// File: rtl/abm_datapath.sv
`timescale 1ns/1ps
module abm_datapath
  import abm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             scanIn,
  input  logic             cmpIn,
  output logic             scanOut,
  output logic [SEG_W-1:0] updWord
);

  logic [SEG_W-1:0] shReg;
  logic [SEG_W-1:0] shNext;

  genvar g;
  generate
    for (g = 0; g < SEG_W; g++) begin : g_cell
      logic capVal;
      logic shVal;
      if (g == B_SENSE) begin : g_sense
        assign capVal = cmpIn;
      end else begin : g_ctl
        assign capVal = updWord[g];
      end
      if (g == SEG_W-1) begin : g_top
        assign shVal = scanIn;
      end else begin : g_mid
        assign shVal = shReg[g+1];
      end
      always_comb begin
        if (strobe.capture)    shNext[g] = capVal;
        else if (strobe.shift) shNext[g] = shVal;
        else                   shNext[g] = shReg[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else       shReg <= shNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              updWord <= '0;
    else if (strobe.update) updWord <= shReg;
  end

  assign scanOut = shReg[0];

endmodule

// File: rtl/abm_switch_map.sv
`timescale 1ns/1ps
module abm_switch_map
  import abm_pkg::*;
(
  input  mode_t            mode,
  input  logic [SEG_W-1:0] updWord,
  output sw_t              sw
);

  logic sense, ctl, drv, obs;
  assign sense = updWord[B_SENSE];
  assign ctl   = updWord[B_MODE];
  assign drv   = updWord[B_DRIVE];
  assign obs   = updWord[B_OBS];

  always_comb begin
    sw = '0;
    unique case (mode)
      MODE_PROBE: begin
        sw.core  = 1'b1;
        sw.drive = drv;
        sw.obs   = obs;
      end
      MODE_EXTEST: begin
        if (ctl) begin
          sw.hi  = sense;
          sw.lo  = ~sense;
          sw.obs = obs;
        end else if (!drv && !obs) begin
          sw.gnd = 1'b1;
        end else begin
          sw.drive = drv;
          sw.obs   = obs;
        end
      end
      default: sw.core = 1'b1;
    endcase
  end

endmodule

// File: rtl/abm_pin_ctrl.sv
`timescale 1ns/1ps
module abm_pin_ctrl
  import abm_pkg::*;
#(
  parameter int              INSTR_W     = 3,
  parameter logic [INSTR_W-1:0] CODE_EXTEST = 3'd0,
  parameter logic [INSTR_W-1:0] CODE_PROBE  = 3'd2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               captureEn,
  input  logic               shiftEn,
  input  logic               updateEn,
  input  logic [INSTR_W-1:0] instr,
  input  logic               scanIn,
  input  logic               cmpIn,
  output logic               scanOut,
  output logic               coreEn,
  output logic               busDriveEn,
  output logic               busObsEn,
  output logic               refHighEn,
  output logic               refLowEn,
  output logic               refGndEn
);

  strobe_t          strobe;
  mode_t            mode;
  logic [SEG_W-1:0] updWord;
  sw_t              sw;

  abm_ctrl #(
    .INSTR_W(INSTR_W), .CODE_EXTEST(CODE_EXTEST), .CODE_PROBE(CODE_PROBE)
  ) u_ctrl (
    .captureEn(captureEn), .shiftEn(shiftEn), .updateEn(updateEn),
    .instr(instr), .strobe(strobe), .mode(mode)
  );

  abm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIn(scanIn),
    .cmpIn(cmpIn), .scanOut(scanOut), .updWord(updWord)
  );

  abm_switch_map u_map (.mode(mode), .updWord(updWord), .sw(sw));

  assign coreEn     = sw.core;
  assign busDriveEn = sw.drive;
  assign busObsEn   = sw.obs;
  assign refHighEn  = sw.hi;
  assign refLowEn   = sw.lo;
  assign refGndEn   = sw.gnd;

endmodule

// File: rtl/abm_pin_ctrl_chk.sv
`timescale 1ns/1ps
module abm_pin_ctrl_chk #(
  parameter int              INSTR_W     = 3,
  parameter logic [INSTR_W-1:0] CODE_EXTEST = 3'd0,
  parameter logic [INSTR_W-1:0] CODE_PROBE  = 3'd2
) (
  input logic               clk,
  input logic               rstN,
  input logic               captureEn,
  input logic               shiftEn,
  input logic               updateEn,
  input logic [INSTR_W-1:0] instr,
  input logic               scanIn,
  input logic               cmpIn,
  input logic               scanOut,
  input logic               coreEn,
  input logic               busDriveEn,
  input logic               busObsEn,
  input logic               refHighEn,
  input logic               refLowEn,
  input logic               refGndEn
);

  logic [5:0] swVec;
  assign swVec = {coreEn, busDriveEn, busObsEn, refHighEn, refLowEn, refGndEn};

  // R9
  single_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({refHighEn, refLowEn, refGndEn, busDriveEn}) <= 1);

  // R2
  capture_sense_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> (scanOut == $past(cmpIn)));

  // R4
  hold_without_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(updateEn) && $stable(instr)) |-> $stable(swVec));

  // R5
  core_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr != CODE_EXTEST) |-> coreEn);

  // R6
  probe_no_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr == CODE_PROBE) |-> (!refHighEn && !refLowEn && !refGndEn));

  // R7
  extest_isolate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr == CODE_EXTEST) |-> !coreEn);

endmodule

bind abm_pin_ctrl abm_pin_ctrl_chk #(
  .INSTR_W(INSTR_W), .CODE_EXTEST(CODE_EXTEST), .CODE_PROBE(CODE_PROBE)
) u_chk (
  .clk(clk), .rstN(rstN), .captureEn(captureEn), .shiftEn(shiftEn),
  .updateEn(updateEn), .instr(instr), .scanIn(scanIn), .cmpIn(cmpIn),
  .scanOut(scanOut), .coreEn(coreEn), .busDriveEn(busDriveEn),
  .busObsEn(busObsEn), .refHighEn(refHighEn), .refLowEn(refLowEn),
  .refGndEn(refGndEn)
);

// File: tb/abm_pin_ctrl_bench.sv
`timescale 1ns/1ps
module abm_pin_ctrl_bench;

  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic captureEn = 1'b0, shiftEn = 1'b0, updateEn = 1'b0;
  logic [IW-1:0] instr = 3'd7;
  logic scanIn = 1'b0, cmpIn = 1'b0;
  logic scanOut, coreEn, busDriveEn, busObsEn, refHighEn, refLowEn, refGndEn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  abm_pin_ctrl u_abm_pin_ctrl (
    .clk(clk), .rstN(rstN), .captureEn(captureEn), .shiftEn(shiftEn),
    .updateEn(updateEn), .instr(instr), .scanIn(scanIn), .cmpIn(cmpIn),
    .scanOut(scanOut), .coreEn(coreEn), .busDriveEn(busDriveEn),
    .busObsEn(busObsEn), .refHighEn(refHighEn), .refLowEn(refLowEn),
    .refGndEn(refGndEn)
  );

  // {core, drive, obs, hi, lo, gnd}; word bit0 sense, 1 mode, 2 drive, 3 obs
  function automatic logic [5:0] expSw(input logic [IW-1:0] ins, input logic [3:0] w);
    logic [5:0] r;
    r = 6'b0;
    if (ins == 3'd2) begin
      r = {1'b1, w[2], w[3], 3'b000};
    end else if (ins == 3'd0) begin
      if (w[1])                r = {1'b0, 1'b0, w[3], w[0], ~w[0], 1'b0};
      else if (!w[2] && !w[3]) r = 6'b000001;
      else                     r = {1'b0, w[2], w[3], 3'b000};
    end else begin
      r = 6'b100000;
    end
    return r;
  endfunction

  function automatic logic [5:0] curSw();
    return {coreEn, busDriveEn, busObsEn, refHighEn, refLowEn, refGndEn};
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // Shift word in LSB first; returns the bits that left the segment.
  task automatic shiftWord(input logic [3:0] w, output logic [3:0] rd);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd[i] = scanOut;
      shiftEn = 1'b1;
      scanIn = w[i];
    end
    @(negedge clk);
    shiftEn = 1'b0;
  endtask

  task automatic doUpdate();
    @(negedge clk); updateEn = 1'b1;
    @(negedge clk); updateEn = 1'b0;
  endtask

  task automatic doCapture(input logic c);
    @(negedge clk); captureEn = 1'b1; cmpIn = c;
    @(negedge clk); captureEn = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] rd, held, w;
    logic [5:0] expd;
    logic c;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R1: reset state under BYPASS
    check("R1 reset bypass", curSw(), 6'b100000);
    rstN = 1'b1;
    @(negedge clk);
    instr = 3'd0;
    #1 check("R1 cleared word under extest", curSw(), 6'b000001);
    instr = 3'd7;

    // R2: capture after reset reads zero control bits and cmpIn
    doCapture(1'b1);
    shiftWord(4'b0000, rd);
    check("R2 capture after reset", {2'b0, rd}, 6'b000001);

    // R3: shift order; word shifted in comes back out unchanged
    shiftWord(4'b1011, rd);
    shiftWord(4'b0110, rd);
    check("R3 shift round trip", {2'b0, rd}, 6'b001011);

    // R4: update makes 0110 live; further shifts do not alter outputs
    instr = 3'd2;
    doUpdate();
    held = 4'b0110;
    check("R6 probe drive", curSw(), expSw(3'd2, held));
    shiftWord(4'b1111, rd);
    doCapture(1'b0);
    check("R4 no update hold", curSw(), expSw(3'd2, held));

    // R2: capture returns live control bits and comparator
    shiftWord(4'b0000, rd);
    check("R2 capture readback", {2'b0, rd}, {2'b0, held[3:1], 1'b0});

    // R10: capture beats shift
    @(negedge clk); captureEn = 1'b1; shiftEn = 1'b1; cmpIn = 1'b1; scanIn = 1'b0;
    @(negedge clk); captureEn = 1'b0; shiftEn = 1'b0;
    shiftWord(4'b0000, rd);
    check("R10 capture priority", {2'b0, rd}, {2'b0, held[3:1], 1'b1});

    // R7 directed: extest high and low drive
    instr = 3'd0;
    shiftWord(4'b0011, rd); doUpdate();
    check("R7 extest high", curSw(), 6'b000100);
    shiftWord(4'b1010, rd); doUpdate();
    check("R7 extest low obs", curSw(), 6'b001010);
    // R8 directed
    shiftWord(4'b0100, rd); doUpdate();
    check("R8 extest bus drive", curSw(), 6'b010000);
    shiftWord(4'b0001, rd); doUpdate();
    check("R8 extest quality ref", curSw(), 6'b000001);

    // R9/R5/R6/R7/R8: exhaustive sweep of words and codes
    for (int ins = 0; ins < 8; ins++) begin
      for (int wi = 0; wi < 16; wi++) begin
        w = wi[3:0];
        instr = ins[2:0];
        shiftWord(w, rd);
        doUpdate();
        expd = expSw(ins[2:0], w);
        check(ins == 0 ? "R7 R8 extest sweep" : (ins == 2 ? "R6 probe sweep" : "R5 functional sweep"),
              curSw(), expd);
        checks++;
        if ($countones({refHighEn, refLowEn, refGndEn, busDriveEn}) > 1) begin
          errors++;
          $display("FAIL R9 sources actual=%b expected=at most one", curSw());
        end
      end
    end

    // Random mix of shift, capture, update and instruction changes
    held = 4'b0000;
    shiftWord(held, rd); doUpdate();
    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom_range(0, 3));
      w = 4'($urandom);
      c = 1'($urandom);
      case (op)
        0: begin
          shiftWord(w, rd);
          doUpdate();
          held = w;
        end
        1: begin
          doCapture(c);
          shiftWord(w, rd);
          check("R2 random capture", {2'b0, rd}, {2'b0, held[3:1], c});
          doUpdate();
          held = w;
        end
        2: begin
          shiftWord(w, rd);
          check("R4 random hold", curSw(), expSw(instr, held));
        end
        default: begin
          instr = 3'($urandom);
          #1;
        end
      endcase
      check("R5 R6 R7 R8 random outputs", curSw(), expSw(instr, held));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule